// File: doc/BRIEF.md
# Multicycle Five-Phase Integer Core

This block is a small unpipelined integer processor for a subset of the RV32 base encoding. It handles one instruction at a time. Each instruction passes through up to five phases: fetch, decode, execute, memory and writeback. Between phases, values live only in internal holding registers: next-PC, instruction, two operands, immediate, ALU result, load data and branch condition.

The core connects to a word-wide instruction port (address in, data out) and a word-wide data port with address, write-enable, write data and read data. Both memories are expected to return read data combinationally in the same cycle. The current program counter and a one-cycle retire pulse are brought out so that an outside observer can follow the instruction stream.

Instruction length depends on its class. Loads and arithmetic need a writeback phase and take five cycles. Stores, branches and unrecognised words take four cycles.

Top module: `mcyc_core`

## Requirements
- R1: While `rst` is high and after it falls, the PC is `RESET_PC` (0 by default), `retire_o` and `dmem_we` are low, and every register holds zero. The first instruction starts in the fetch phase on the first clock edge with `rst` low.
- R2: An instruction with major opcode 0110011, 0010011 or 0000011 takes 5 clock cycles. All other instructions take 4 cycles. `retire_o` is high for exactly the final cycle of each instruction.
- R3: Major opcode 0110011 with funct3 (bits 14:12) 000 adds rs1 (bits 19:15) and rs2 (bits 24:20), or subtracts rs2 from rs1 when bit 30 is set. The same opcode with funct3 110 gives OR and with funct3 111 gives AND. The result goes to rd (bits 11:7).
- R4: Major opcode 0010011 with funct3 000, 110 or 111 adds, ORs or ANDs rs1 with the 12-bit signed immediate in bits 31:20, sign-extended to 32 bits. The range -2048..+2047 is fully usable.
- R5: Major opcode 0000011 writes to rd the data word at address rs1 + sign-extended bits 31:20.
- R6: Major opcode 0100011 drives `dmem_addr` = rs1 + sign-extended {bits 31:25, bits 11:7} and `dmem_wdata` = rs2. It raises `dmem_we` for exactly one cycle, the instruction's last.
- R7: Major opcode 1100011 tests only rs1. Funct3 000 branches when rs1 is zero and funct3 001 branches when rs1 is non-zero. The target is the instruction's own PC plus the signed offset {bit 31, bit 7, bits 30:25, bits 11:8, 0}, which allows forward and backward targets. When the branch is not taken the next PC is PC+4.
- R8: Register 0 reads as zero, and a write addressed to it has no effect.
- R9: Any other opcode, or any funct3 not listed above, acts as a no-op. It takes 4 cycles, writes neither a register nor memory, and continues at PC+4.
- R10: Outside a taken branch the next PC is PC+4. `imem_addr` and `pc_o` both show the PC. The PC changes only at the end of the memory phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | XLEN | Instruction fetch address |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | XLEN | Data access address |
| dmem_we | output | 1 | Data write enable |
| dmem_wdata | output | XLEN | Data to write |
| dmem_rdata | input | XLEN | Data word at `dmem_addr` |
| pc_o | output | XLEN | Current program counter |
| retire_o | output | 1 | High in the last cycle of each instruction |

## Verification
The bench builds the core with its defaults: XLEN of 32, thirty-two registers and a start address of 0. A 32-bit datapath lets the test reach the -2048 immediate edge and see full sign extension in AND/OR results whose upper bits are all ones. A zero start address lets the program place stores at small absolute addresses with base register 0, and use a negative displacement from a non-zero base. Register 12 is never written, so its reset value of zero drives a taken zero-test branch. A backward branch and a no-op whose rd field names a live register are also exercised.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    typedef enum logic [2:0] {
        PH_IF  = 3'd0,
        PH_ID  = 3'd1,
        PH_EX  = 3'd2,
        PH_MEM = 3'd3,
        PH_WB  = 3'd4
    } phase_e;

    typedef enum logic [2:0] {
        CL_NOP    = 3'd0,
        CL_ALU    = 3'd1,
        CL_LOAD   = 3'd2,
        CL_STORE  = 3'd3,
        CL_BRANCH = 3'd4
    } iclass_e;

    typedef enum logic [1:0] {
        AO_ADD = 2'd0,
        AO_SUB = 2'd1,
        AO_AND = 2'd2,
        AO_OR  = 2'd3
    } aluop_e;

    localparam logic [6:0] OPC_ALU_R  = 7'b0110011;
    localparam logic [6:0] OPC_ALU_I  = 7'b0010011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;

    localparam int RF_AW = 5;

endpackage

// File: rtl/mcyc_decode.sv
module mcyc_decode
    import mcyc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]      ir,
    output iclass_e          iclass,
    output aluop_e           aluop,
    output logic             use_imm,
    output logic [XLEN-1:0]  imm,
    output logic [RF_AW-1:0] rs1,
    output logic [RF_AW-1:0] rs2,
    output logic [RF_AW-1:0] rd,
    output logic [2:0]       funct3
);

    logic [6:0] opc;

    always_comb begin
        opc     = ir[6:0];
        funct3  = ir[14:12];
        rs1     = ir[19:15];
        rs2     = ir[24:20];
        rd      = ir[11:7];
        iclass  = CL_NOP;
        aluop   = AO_ADD;
        use_imm = 1'b1;
        imm     = {{(XLEN-12){ir[31]}}, ir[31:20]};
        unique case (opc)
            OPC_ALU_R, OPC_ALU_I: begin
                use_imm = (opc == OPC_ALU_I);
                iclass  = CL_ALU;
                case (funct3)
                    3'b000:  aluop = (opc == OPC_ALU_R && ir[30]) ? AO_SUB : AO_ADD;
                    3'b110:  aluop = AO_OR;
                    3'b111:  aluop = AO_AND;
                    default: iclass = CL_NOP;
                endcase
            end
            OPC_LOAD:   iclass = CL_LOAD;
            OPC_STORE: begin
                iclass = CL_STORE;
                imm    = {{(XLEN-12){ir[31]}}, ir[31:25], ir[11:7]};
            end
            OPC_BRANCH: begin
                iclass = CL_BRANCH;
                imm    = {{(XLEN-13){ir[31]}}, ir[31], ir[7], ir[30:25], ir[11:8], 1'b0};
            end
            default:    iclass = CL_NOP;
        endcase
    end

endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
    import mcyc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  aluop_e          op,
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    output logic [XLEN-1:0] res
);

    always_comb begin
        unique case (op)
            AO_ADD:  res = lhs + rhs;
            AO_SUB:  res = lhs - rhs;
            AO_AND:  res = lhs & rhs;
            AO_OR:   res = lhs | rhs;
            default: res = lhs + rhs;
        endcase
    end

endmodule

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr1,
    output logic [XLEN-1:0] rdata1,
    input  logic [AW-1:0]   raddr2,
    output logic [XLEN-1:0] rdata2
);

    logic [XLEN-1:0] view [NREGS];

    // Entry 0 has no storage: it is tied to zero.
    assign view[0] = '0;

    for (genvar g = 1; g < NREGS; g++) begin : g_entry
        logic [XLEN-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst)
                val_q <= '0;
            else if (we && waddr == AW'(g))
                val_q <= wdata;
        end
        assign view[g] = val_q;
    end

    assign rdata1 = view[raddr1];
    assign rdata2 = view[raddr2];

    AST_X0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (raddr1 == '0) |-> (rdata1 == '0)); // R8

endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
    import mcyc_pkg::*;
#(
    parameter int           XLEN     = 32,
    parameter int           NREGS    = 32,
    parameter logic [31:0]  RESET_PC = 32'h0
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic            dmem_we,
    output logic [XLEN-1:0] dmem_wdata,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic [XLEN-1:0] pc_o,
    output logic            retire_o
);

    localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

    typedef struct packed {
        phase_e          phase;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
        logic [31:0]     ir;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] imm;
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] lmd;
        logic            cond;
    } core_st_t;

    core_st_t s_d, s_q;

    iclass_e          dec_class;
    aluop_e           dec_op;
    logic             dec_use_imm;
    logic [XLEN-1:0]  dec_imm;
    logic [RF_AW-1:0] dec_rs1, dec_rs2, dec_rd;
    logic [2:0]       dec_f3;

    logic [XLEN-1:0]  rf_rd1, rf_rd2, rf_wdata;
    logic             rf_we;
    logic [XLEN-1:0]  alu_lhs, alu_rhs, alu_res;
    aluop_e           alu_op;
    logic             has_wb;
    logic             zero_hit;

    mcyc_decode #(.XLEN(XLEN)) i_decode (
        .ir      (s_q.ir),
        .iclass  (dec_class),
        .aluop   (dec_op),
        .use_imm (dec_use_imm),
        .imm     (dec_imm),
        .rs1     (dec_rs1),
        .rs2     (dec_rs2),
        .rd      (dec_rd),
        .funct3  (dec_f3)
    );

    mcyc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) i_regfile (
        .clk    (clk),
        .rst    (rst),
        .we     (rf_we),
        .waddr  (dec_rd),
        .wdata  (rf_wdata),
        .raddr1 (dec_rs1),
        .rdata1 (rf_rd1),
        .raddr2 (dec_rs2),
        .rdata2 (rf_rd2)
    );

    mcyc_alu #(.XLEN(XLEN)) i_alu (
        .op  (alu_op),
        .lhs (alu_lhs),
        .rhs (alu_rhs),
        .res (alu_res)
    );

    always_comb begin
        has_wb   = (dec_class == CL_ALU) || (dec_class == CL_LOAD);
        alu_op   = (dec_class == CL_ALU) ? dec_op : AO_ADD;
        alu_lhs  = (dec_class == CL_BRANCH) ? s_q.pc : s_q.a;
        alu_rhs  = (dec_class == CL_ALU && !dec_use_imm) ? s_q.b : s_q.imm;
        zero_hit = (s_q.a == '0);
        rf_we    = (s_q.phase == PH_WB) && has_wb;
        rf_wdata = (dec_class == CL_LOAD) ? s_q.lmd : s_q.alu;

        s_d = s_q;
        unique case (s_q.phase)
            PH_IF: begin
                s_d.ir    = imem_rdata;
                s_d.npc   = s_q.pc + PC_STEP;
                s_d.phase = PH_ID;
            end
            PH_ID: begin
                s_d.a     = rf_rd1;
                s_d.b     = rf_rd2;
                s_d.imm   = dec_imm;
                s_d.phase = PH_EX;
            end
            PH_EX: begin
                s_d.alu   = alu_res;
                s_d.cond  = (dec_class == CL_BRANCH) &&
                            ((dec_f3 == 3'b000 &&  zero_hit) ||
                             (dec_f3 == 3'b001 && !zero_hit));
                s_d.phase = PH_MEM;
            end
            PH_MEM: begin
                s_d.pc    = s_q.cond ? s_q.alu : s_q.npc;
                if (dec_class == CL_LOAD)
                    s_d.lmd = dmem_rdata;
                s_d.phase = has_wb ? PH_WB : PH_IF;
            end
            PH_WB:   s_d.phase = PH_IF;
            default: s_d.phase = PH_IF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q       <= '0;
            s_q.phase <= PH_IF;
            s_q.pc    <= RESET_PC[XLEN-1:0];
        end else begin
            s_q <= s_d;
        end
    end

    assign imem_addr  = s_q.pc;
    assign pc_o       = s_q.pc;
    assign dmem_addr  = s_q.alu;
    assign dmem_wdata = s_q.b;
    assign dmem_we    = (s_q.phase == PH_MEM) && (dec_class == CL_STORE);
    assign retire_o   = (s_q.phase == PH_WB) || ((s_q.phase == PH_MEM) && !has_wb);

    AST_RETIRE_PULSE: assert property (@(posedge clk) disable iff (rst)
        retire_o |=> !retire_o); // R2

    AST_STORE_PULSE: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> !dmem_we); // R6

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase != PH_MEM) |=> $stable(pc_o)); // R10

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (dec_class == CL_NOP && s_q.phase != PH_IF) |-> (!dmem_we && !rf_we)); // R9

    AST_WB_LAST: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> retire_o); // R2

endmodule

// File: tb/test_mcyc_core.sv
module test_mcyc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata, pc_o, imem_rdata;
    logic        dmem_we, retire_o;

    always #5 clk = ~clk;

    mcyc_core i_mcyc_core (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .pc_o       (pc_o),
        .retire_o   (retire_o)
    );

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'b0110011};
    endfunction
    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction
    function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                          input logic [4:0] rs1);
        return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] enc_b(input logic [12:0] off, input logic [4:0] rs1,
                                          input logic [2:0] f3);
        return {off[12], off[10:5], 5'd0, rs1, f3, off[4:1], off[11], 7'b1100011};
    endfunction

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] ins;
        logic [2:0]  len;
        logic [31:0] nxt;
        logic        st;
        logic [31:0] sa;
        logic [31:0] sd;
        logic [3:0]  rqd;
        logic [3:0]  rqp;
    } vec_t;

    localparam int NV = 26;
    localparam logic [6:0] OI = 7'b0010011;
    localparam logic [6:0] OL = 7'b0000011;

    localparam vec_t TBL [NV] = '{
        '{32'd0,   enc_i(12'd5,   5'd0, 3'b000, 5'd1, OI),          3'd5, 32'd4,   1'b0, 32'd0,  32'd0,         4'd4, 4'd10}, // R4 addi x1=5
        '{32'd4,   enc_i(12'hFFC, 5'd0, 3'b000, 5'd2, OI),          3'd5, 32'd8,   1'b0, 32'd0,  32'd0,         4'd4, 4'd10}, // R4 addi x2=-4
        '{32'd8,   enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd3),          3'd5, 32'd12,  1'b0, 32'd0,  32'd0,         4'd3, 4'd10}, // R3 add
        '{32'd12,  enc_r(7'h20, 5'd2, 5'd1, 3'b000, 5'd4),          3'd5, 32'd16,  1'b0, 32'd0,  32'd0,         4'd3, 4'd10}, // R3 sub
        '{32'd16,  enc_s(12'd0,  5'd3, 5'd0),                       3'd4, 32'd20,  1'b1, 32'd0,  32'd1,         4'd3, 4'd10}, // R3 R6
        '{32'd20,  enc_s(12'd4,  5'd4, 5'd0),                       3'd4, 32'd24,  1'b1, 32'd4,  32'd9,         4'd3, 4'd10}, // R3 R6
        '{32'd24,  enc_r(7'h00, 5'd2, 5'd1, 3'b111, 5'd5),          3'd5, 32'd28,  1'b0, 32'd0,  32'd0,         4'd3, 4'd10}, // R3 and
        '{32'd28,  enc_r(7'h00, 5'd2, 5'd1, 3'b110, 5'd6),          3'd5, 32'd32,  1'b0, 32'd0,  32'd0,         4'd3, 4'd10}, // R3 or
        '{32'd32,  enc_s(12'd8,  5'd5, 5'd0),                       3'd4, 32'd36,  1'b1, 32'd8,  32'd4,         4'd3, 4'd10}, // R3 and result
        '{32'd36,  enc_s(12'd12, 5'd6, 5'd0),                       3'd4, 32'd40,  1'b1, 32'd12, 32'hFFFFFFFD,  4'd3, 4'd10}, // R3 or result
        '{32'd40,  enc_i(12'h0F0, 5'd6, 3'b111, 5'd7, OI),          3'd5, 32'd44,  1'b0, 32'd0,  32'd0,         4'd4, 4'd10}, // R4 andi
        '{32'd44,  enc_i(12'h800, 5'd1, 3'b110, 5'd8, OI),          3'd5, 32'd48,  1'b0, 32'd0,  32'd0,         4'd4, 4'd10}, // R4 ori -2048
        '{32'd48,  enc_s(12'd16, 5'd7, 5'd0),                       3'd4, 32'd52,  1'b1, 32'd16, 32'h000000F0,  4'd4, 4'd10}, // R4
        '{32'd52,  enc_s(12'd20, 5'd8, 5'd0),                       3'd4, 32'd56,  1'b1, 32'd20, 32'hFFFFF805,  4'd4, 4'd10}, // R4
        '{32'd56,  enc_i(12'd7,   5'd0, 3'b000, 5'd0, OI),          3'd5, 32'd60,  1'b0, 32'd0,  32'd0,         4'd8, 4'd10}, // R8 write x0
        '{32'd60,  enc_s(12'd24, 5'd0, 5'd0),                       3'd4, 32'd64,  1'b1, 32'd24, 32'd0,         4'd8, 4'd10}, // R8 x0 still 0
        '{32'd64,  enc_i(12'd4,   5'd0, 3'b010, 5'd9, OL),          3'd5, 32'd68,  1'b0, 32'd0,  32'd0,         4'd5, 4'd10}, // R5 lw x9
        '{32'd68,  enc_i(12'd64,  5'd0, 3'b000, 5'd10, OI),         3'd5, 32'd72,  1'b0, 32'd0,  32'd0,         4'd4, 4'd10}, // R4 base
        '{32'd72,  enc_s(12'hFF8, 5'd9, 5'd10),                     3'd4, 32'd76,  1'b1, 32'd56, 32'd9,         4'd5, 4'd10}, // R5 R6 neg disp
        '{32'd76,  enc_i(12'hFF8, 5'd10, 3'b010, 5'd11, OL),        3'd5, 32'd80,  1'b0, 32'd0,  32'd0,         4'd5, 4'd10}, // R5 lw x11
        '{32'd80,  enc_b(13'd12,   5'd12, 3'b000),                  3'd4, 32'd92,  1'b0, 32'd0,  32'd0,         4'd7, 4'd7},  // R7 R1 taken
        '{32'd92,  enc_b(13'd40,   5'd11, 3'b000),                  3'd4, 32'd96,  1'b0, 32'd0,  32'd0,         4'd7, 4'd7},  // R7 not taken
        '{32'd96,  enc_b(13'd20,   5'd0,  3'b000),                  3'd4, 32'd116, 1'b0, 32'd0,  32'd0,         4'd7, 4'd7},  // R7 taken
        '{32'd116, enc_b(13'h1FF4, 5'd11, 3'b001),                  3'd4, 32'd104, 1'b0, 32'd0,  32'd0,         4'd7, 4'd7},  // R7 backward
        '{32'd104, {20'd0, 5'd11, 7'b1111111},                      3'd4, 32'd108, 1'b0, 32'd0,  32'd0,         4'd9, 4'd9},  // R9 no-op
        '{32'd108, enc_s(12'd28, 5'd11, 5'd0),                      3'd4, 32'd112, 1'b1, 32'd28, 32'd9,         4'd9, 4'd10}  // R9 x11 intact
    };

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    int          cyc;
    int          n_run = 0;
    int          n_fail = 0;
    int          wd = 0;

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
        if (rst) cyc <= 0; else cyc <= cyc + 1;
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > 20000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp=<20000", wd);
            summary();
        end
    end

    task automatic chk(input logic ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    initial begin
        int prev;
        for (int k = 0; k < 64; k++) begin
            imem[k] = 32'd0;
            dmem[k] = 32'd0;
        end
        for (int k = 0; k < NV; k++) imem[TBL[k].pc[7:2]] = TBL[k].ins;
        imem[21] = enc_s(12'd60, 5'd1, 5'd0);  // skipped slots
        imem[22] = enc_s(12'd60, 5'd1, 5'd0);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(pc_o == 32'd0, "R1", "pc in reset", pc_o, 32'd0);
        chk(retire_o == 1'b0, "R1", "retire in reset", {31'd0, retire_o}, 32'd0);
        chk(dmem_we == 1'b0, "R1", "we in reset", {31'd0, dmem_we}, 32'd0);
        rst = 1'b0;
        prev = -1;

        for (int i = 0; i < NV; i++) begin
            do @(negedge clk); while (!retire_o);
            chk((cyc - prev) == int'(TBL[i].len), "R2", $sformatf("length @%0d", TBL[i].pc),
                32'(cyc - prev), 32'(TBL[i].len));
            prev = cyc;
            if (TBL[i].st) begin
                chk(dmem_we && dmem_addr == TBL[i].sa, $sformatf("R%0d", TBL[i].rqd),
                    "store addr", dmem_addr, TBL[i].sa);
                chk(dmem_wdata == TBL[i].sd, $sformatf("R%0d", TBL[i].rqd),
                    "store data", dmem_wdata, TBL[i].sd);
            end else if (TBL[i].len == 3'd4) begin
                chk(!dmem_we, $sformatf("R%0d", TBL[i].rqd), "no write", {31'd0, dmem_we}, 32'd0);
            end
            @(negedge clk);
            chk(pc_o == TBL[i].nxt && imem_addr == TBL[i].nxt, $sformatf("R%0d", TBL[i].rqp),
                $sformatf("next pc @%0d", TBL[i].pc), pc_o, TBL[i].nxt);
            if (TBL[i].len == 3'd4)
                chk(!retire_o, "R2", "retire one cycle", {31'd0, retire_o}, 32'd0);
        end

        // R1: reset mid-run, restart from 0 with fresh fetch
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(pc_o == 32'd0, "R1", "pc after re-reset", pc_o, 32'd0);
        chk(!retire_o && !dmem_we, "R1", "quiet after re-reset", {30'd0, retire_o, dmem_we}, 32'd0);
        rst = 1'b0;
        do @(negedge clk); while (!retire_o);
        chk(cyc == 4, "R1", "first retire cycle", 32'(cyc), 32'd4);
        @(negedge clk);
        chk(pc_o == 32'd4, "R10", "pc after first", pc_o, 32'd4);

        summary();
    end

endmodule